// File: doc/BRIEF.md
# Hidden Register Diagnostic Readout

This unit gives a production tester a way to observe eighteen single-bit registers that have no path to the pins during normal operation. There are four counter-control flags, eight internal state bits and the six bits of the binary counter. The tester first disables the block's outputs. It then drives a designated output pin to a super-high level. Three select lines, each with three voltage levels, then form a base-3 address, and the addressed bit appears on a single readout output.

The analog over-voltage detection sits outside this unit. Every pin level reaches the unit as a 2-bit code: 0 is low, 1 is high, 2 is super-high and 3 is an illegal level. The unit only reads the registers. A programmable settling count stands in for the minimum time a tester must wait after each step. The unit raises a valid flag only after that count has elapsed with the address held steady. When an address selects no register, the readout is forced low and a flag reports the bad address.

Top module: `diag_readout`

## Requirements
- R1: After synchronous reset, diag_active, rd_bit, rd_valid and rd_bad_addr are all 0.
- R2: diag_active rises on the clock edge after oe_n_pin is 1 and entry_lvl is 2, provided the entry sequence was respected. It never rises unless both conditions held in the preceding cycle.
- R3: The sequence state is captured in the last cycle with oe_n_pin at 0 and is kept while oe_n_pin stays 1. If entry_lvl was already 2 in that last cycle, entry is refused until oe_n_pin returns to 0.
- R4: When oe_shared is 1, gate_lvl must be 2 in the last cycle with oe_n_pin at 0, otherwise entry is refused. When oe_shared is 0, gate_lvl is ignored.
- R5: sel_lvl carries three 2-bit digits with the most significant in bits [5:4] and the least in [1:0]. The address is hi*9 + mid*3 + lo.
- R6: Address 0-3 reads clr_regs[0..3], 4-11 reads state_regs[0..7], 12-17 reads ctr_regs[0..5]. From the second edge after a step, rd_bit shows the selected bit.
- R7: rd_valid rises on exactly the (settle_cycles+2)th edge after entry or after an address change, counting the first edge that sees the step. It falls on the first edge that sees an address change.
- R8: Addresses 18-26, or any digit at code 3, give rd_bad_addr = 1 with rd_bit = 0 and rd_valid = 0 from the second edge on.
- R9: diag_active, rd_bit, rd_valid and rd_bad_addr all go to 0 on the edge after oe_n_pin falls to 0 or entry_lvl leaves 2.
- R10: Leaving and re-entering diagnostic mode leaves the observed registers unchanged, so the same address reads the same value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n_pin | input | 1 | Output-enable pin level; 1 disables outputs |
| oe_shared | input | 1 | 1 when the enable pin also serves as a logic input |
| gate_lvl | input | 2 | Level code of the input that must be super-high before disabling |
| entry_lvl | input | 2 | Level code of the output pin used to request diagnostic mode |
| sel_lvl | input | 6 | Three select level codes, most significant digit in the top bits |
| settle_cycles | input | 8 | Settling cycles required before readout is valid |
| clr_regs | input | 4 | Counter clear/hold control flags |
| state_regs | input | 8 | Internal state bits |
| ctr_regs | input | 6 | Counter bits |
| diag_active | output | 1 | Diagnostic mode is active |
| rd_bit | output | 1 | Value of the selected register |
| rd_valid | output | 1 | Readout has settled and addresses a real register |
| rd_bad_addr | output | 1 | Current address selects no register |

## Verification
The bench attacks the entry gate: outputs disabled only after the entry pin went super-high, and the shared enable pin with the gating input low. An entry check that looks at present levels instead of the captured sequence would enter in those cases. It changes address on every window with random settle counts, so a timer that is not restarted by an address change, or that is off by one, asserts valid on the wrong edge. Unused addresses and code-3 digits are mixed in, which catches a mux that indexes past its sources or flags only one kind of bad address. Exit followed by re-entry shows whether stale readout data survives the exit.

// File: rtl/diag_rd_pkg.sv
package diag_rd_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_LOW   = 2'd0,
    LVL_HIGH  = 2'd1,
    LVL_SUPER = 2'd2,
    LVL_BAD   = 2'd3
  } lvl_e;
endpackage

// File: rtl/diag_tri_addr.sv
module diag_tri_addr
  import diag_rd_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int ADDR_W = 5
) (
  input  logic [DIGITS-1:0][LVL_W-1:0] digit,
  output logic [ADDR_W-1:0]            addr
);
  logic [ADDR_W-1:0] part [0:DIGITS];
  logic [DIGITS-1:0] bad;

  assign part[0] = '0;

  // Digit i carries weight 3**i; any code-3 digit poisons the address.
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    localparam int WEIGHT = 3 ** i;
    assign part[i+1] = part[i] + ADDR_W'(digit[i]) * ADDR_W'(WEIGHT);
    assign bad[i]    = (digit[i] == LVL_BAD);
  end

  assign addr = (|bad) ? '1 : part[DIGITS];
endmodule

// File: rtl/diag_entry_seq.sv
module diag_entry_seq
  import diag_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n_pin,
  input  logic             oe_shared,
  input  logic [LVL_W-1:0] gate_lvl,
  input  logic [LVL_W-1:0] entry_lvl,
  output logic             active_d,
  output logic             active_q
);
  logic seq_ok_q;

  // Sequence legality is judged in the last cycle the outputs were enabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_ok_q <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (!oe_n_pin)
        seq_ok_q <= (entry_lvl != LVL_SUPER) &&
                    (!oe_shared || (gate_lvl == LVL_SUPER));
      active_q <= active_d;
    end
  end

  assign active_d = oe_n_pin && (entry_lvl == LVL_SUPER) && seq_ok_q;
endmodule

// File: rtl/diag_settle_tmr.sv
module diag_settle_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (!run || restart)
      cnt_q <= '0;
    else if (cnt_q < limit)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q >= limit);
endmodule

// File: rtl/diag_src_mux.sv
module diag_src_mux #(
  parameter int N_SRC  = 18,
  parameter int ADDR_W = 5
) (
  input  logic [N_SRC-1:0]  src,
  input  logic [ADDR_W-1:0] addr,
  output logic              bit_o,
  output logic              legal
);
  assign legal = (addr < ADDR_W'(N_SRC));

  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (addr == ADDR_W'(i)) bit_o = src[i];
  end
endmodule

// File: rtl/diag_readout.sv
module diag_readout
  import diag_rd_pkg::*;
#(
  parameter int N_CLR      = 4,
  parameter int N_STATE    = 8,
  parameter int N_CTR      = 6,
  parameter int SEL_DIGITS = 3,
  parameter int SETTLE_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        oe_n_pin,
  input  logic                        oe_shared,
  input  logic [1:0]                  gate_lvl,
  input  logic [1:0]                  entry_lvl,
  input  logic [2*SEL_DIGITS-1:0]     sel_lvl,
  input  logic [SETTLE_W-1:0]         settle_cycles,
  input  logic [N_CLR-1:0]            clr_regs,
  input  logic [N_STATE-1:0]          state_regs,
  input  logic [N_CTR-1:0]            ctr_regs,
  output logic                        diag_active,
  output logic                        rd_bit,
  output logic                        rd_valid,
  output logic                        rd_bad_addr
);
  localparam int N_SRC  = N_CLR + N_STATE + N_CTR;
  localparam int ADDR_W = $clog2(3 ** SEL_DIGITS);

  logic [SEL_DIGITS-1:0][LVL_W-1:0] digits;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [N_SRC-1:0]  src;
  logic active_d, active_q, run, restart, done, legal_q, mux_bit;
  logic bit_q, valid_q, bad_q;

  assign digits = sel_lvl;
  assign src    = {ctr_regs, state_regs, clr_regs};

  diag_tri_addr #(.DIGITS(SEL_DIGITS), .ADDR_W(ADDR_W)) u_addr (
    .digit (digits),
    .addr  (addr_d)
  );

  diag_entry_seq u_entry (
    .clk       (clk),
    .rst       (rst),
    .oe_n_pin  (oe_n_pin),
    .oe_shared (oe_shared),
    .gate_lvl  (gate_lvl),
    .entry_lvl (entry_lvl),
    .active_d  (active_d),
    .active_q  (active_q)
  );

  assign run     = active_q && active_d;
  assign restart = (addr_d != addr_q);

  diag_settle_tmr #(.CNT_W(SETTLE_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (restart),
    .limit   (settle_cycles),
    .done    (done)
  );

  diag_src_mux #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_mux (
    .src   (src),
    .addr  (addr_q),
    .bit_o (mux_bit),
    .legal (legal_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      bit_q   <= run && legal_q && mux_bit;
      valid_q <= run && legal_q && !restart && done;
      bad_q   <= run && !legal_q;
    end
  end

  assign diag_active = active_q;
  assign rd_bit      = bit_q;
  assign rd_valid    = valid_q;
  assign rd_bad_addr = bad_q;
endmodule

// File: rtl/diag_readout_chk.sv
module diag_readout_chk #(
  parameter int SEL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_n_pin,
  input logic [1:0]       entry_lvl,
  input logic [SEL_W-1:0] sel_lvl,
  input logic             diag_active,
  input logic             rd_bit,
  input logic             rd_valid,
  input logic             rd_bad_addr
);
  // R2: entry only follows a disabled-output, super-high request cycle
  a_r2_entry_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(diag_active) |-> ($past(oe_n_pin) && ($past(entry_lvl) == 2'd2)));

  // R9: dropping either condition ends the mode on the next edge
  a_r9_exit_on_release: assert property (@(posedge clk) disable iff (rst)
    (!$past(oe_n_pin) || ($past(entry_lvl) != 2'd2)) |-> !diag_active);

  // R9: no readout activity outside diagnostic mode
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !diag_active |-> (!rd_bit && !rd_valid && !rd_bad_addr));

  // R8: a bad address never produces data or a valid flag
  a_r8_bad_addr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rd_bad_addr |-> (!rd_bit && !rd_valid));

  // R7: valid only after the select lines held across the previous edge
  a_r7_valid_needs_stable_select: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(sel_lvl) == $past(sel_lvl, 2)));
endmodule

bind diag_readout diag_readout_chk #(.SEL_W(2*SEL_DIGITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .oe_n_pin    (oe_n_pin),
  .entry_lvl   (entry_lvl),
  .sel_lvl     (sel_lvl),
  .diag_active (diag_active),
  .rd_bit      (rd_bit),
  .rd_valid    (rd_valid),
  .rd_bad_addr (rd_bad_addr)
);

// File: tb/diag_readout_tb.sv
`timescale 1ns/1ps
module diag_readout_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       oe_n_pin = 1'b0;
  logic       oe_shared = 1'b0;
  logic [1:0] gate_lvl = 2'd0;
  logic [1:0] entry_lvl = 2'd0;
  logic [5:0] sel_lvl = 6'd0;
  logic [7:0] settle_cycles = 8'd0;
  logic [3:0] clr_regs = 4'd0;
  logic [7:0] state_regs = 8'd0;
  logic [5:0] ctr_regs = 6'd0;
  logic diag_active, rd_bit, rd_valid, rd_bad_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  diag_readout u_dut (
    .clk(clk), .rst(rst), .oe_n_pin(oe_n_pin), .oe_shared(oe_shared),
    .gate_lvl(gate_lvl), .entry_lvl(entry_lvl), .sel_lvl(sel_lvl),
    .settle_cycles(settle_cycles), .clr_regs(clr_regs),
    .state_regs(state_regs), .ctr_regs(ctr_regs),
    .diag_active(diag_active), .rd_bit(rd_bit), .rd_valid(rd_valid),
    .rd_bad_addr(rd_bad_addr)
  );

  function automatic int addr_of(input logic [5:0] s);
    if (s[5:4] == 2'd3 || s[3:2] == 2'd3 || s[1:0] == 2'd3) return 99;
    return int'(s[5:4]) * 9 + int'(s[3:2]) * 3 + int'(s[1:0]);
  endfunction

  function automatic logic exp_bit(input int a);
    logic [17:0] all;
    all = {ctr_regs, state_regs, clr_regs};
    if (a < 18) return all[a];
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // After a step was applied before edge 1, run 'len' edges and check each.
  task automatic window(input int len, input string req);
    int a;
    int s;
    a = addr_of(sel_lvl);
    s = int'(settle_cycles);
    for (int n = 1; n <= len; n++) begin
      step();
      if (n == 1) check({req, " valid low on step edge"}, rd_valid, 0);
      else begin
        check({req, " bad flag"}, rd_bad_addr, (a >= 18) ? 1 : 0);
        check({req, " readout bit"}, rd_bit, exp_bit(a));
        check({req, " valid timing"}, rd_valid, (a < 18 && n >= s + 2) ? 1 : 0);
      end
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [5:0] nsel;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 diag_active", diag_active, 0);
    check("R1 rd_bit", rd_bit, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 rd_bad_addr", rd_bad_addr, 0);

    clr_regs = 4'b1010; state_regs = 8'h5C; ctr_regs = 6'b100111;
    settle_cycles = 8'd2;
    sel_lvl = {2'd0, 2'd1, 2'd2};  // address 5 -> state bit 1

    // R2 normal entry
    step();
    oe_n_pin = 1'b1;
    step();
    check("R2 no entry without super-high", diag_active, 0);
    entry_lvl = 2'd2;
    window(6, "R2/R6/R7 entry");
    check("R2 diag_active after request", diag_active, 1);

    // R9 exit via entry level
    entry_lvl = 2'd1;
    step();
    check("R9 exit diag_active", diag_active, 0);
    check("R9 exit rd_valid", rd_valid, 0);
    check("R9 exit rd_bit", rd_bit, 0);

    // R10 re-entry reads the same bit; choose a bit that is 1
    sel_lvl = {2'd0, 2'd1, 2'd1};  // address 4 -> state bit 0 = 0
    sel_lvl = {2'd0, 2'd2, 2'd0};  // address 6 -> state bit 2 = 1
    step();
    entry_lvl = 2'd2;
    window(5, "R10 re-entry");
    check("R10 same value after re-entry", rd_bit, 1);

    // R5/R6 boundary addresses
    sel_lvl = {2'd0, 2'd0, 2'd0}; window(5, "R5/R6 addr 0");
    sel_lvl = {2'd0, 2'd1, 2'd0}; window(5, "R5/R6 addr 3");
    sel_lvl = {2'd1, 2'd1, 2'd0}; window(5, "R5/R6 addr 12");
    sel_lvl = {2'd1, 2'd2, 2'd2}; window(5, "R5/R6 addr 17");
    sel_lvl = {2'd2, 2'd0, 2'd0}; window(5, "R8 addr 18");
    sel_lvl = {2'd2, 2'd2, 2'd2}; window(5, "R8 addr 26");
    sel_lvl = {2'd0, 2'd3, 2'd0}; window(5, "R8 code 3 digit");

    // R9 exit via enable low
    oe_n_pin = 1'b0;
    step();
    check("R9 exit on enable low", diag_active, 0);
    check("R9 bad flag cleared", rd_bad_addr, 0);

    // R3 super-high before disabling is refused
    entry_lvl = 2'd2;
    step();
    oe_n_pin = 1'b1;
    step(); step();
    check("R3 wrong order refused", diag_active, 0);
    entry_lvl = 2'd0; step();
    entry_lvl = 2'd2; step();
    check("R3 refusal persists while disabled", diag_active, 0);

    // R4 shared enable pin gating
    oe_n_pin = 1'b0; entry_lvl = 2'd0; oe_shared = 1'b1; gate_lvl = 2'd1;
    step();
    oe_n_pin = 1'b1; step();
    entry_lvl = 2'd2; step();
    check("R4 refused without gate", diag_active, 0);
    oe_n_pin = 1'b0; entry_lvl = 2'd0; gate_lvl = 2'd2;
    step();
    oe_n_pin = 1'b1; step();
    gate_lvl = 2'd0;
    entry_lvl = 2'd2; step();
    check("R4 entered with gate", diag_active, 1);

    // Random windows: address always changes, settle and registers vary
    for (int w = 0; w < 200; w++) begin
      do begin
        for (int d = 0; d < 3; d++)
          nsel[2*d +: 2] = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      end while (nsel == sel_lvl);
      sel_lvl = nsel;
      settle_cycles = 8'($urandom_range(0, 3));
      clr_regs = 4'($urandom);
      state_regs = 8'($urandom);
      ctr_regs = 6'($urandom);
      window($urandom_range(1, int'(settle_cycles) + 4), "R5/R6/R7/R8 random");
    end

    report();
  end
endmodule